// File: doc/BRIEF.md
# Wake-on-LAN Power Mode Controller

This block moves a network controller into a low-power listening state in which it waits for a wake frame, and brings it back out again. Entry takes three steps in a fixed order. The controller must first report that it has suspended and that its traffic has drained. Software then sets a mode-select bit. Finally, either a hardware sleep pin or a software enable bit is raised. While the state is active, the block holds off bus-master cycles and transmit starts. Reception carries on, but every received frame is flushed. Slave register access is not affected.

A frame matcher outside the block sends a one-cycle detect pulse when it finds a wake frame. The block latches this into a sticky status bit. It reports wake by an interrupt, which needs two enables, or by an indicator pin whose active level can be programmed. The listening state ends on the first falling edge of the sleep pin or of the software enable. Normal operation then resumes without reinitialization. After an exit caused by the pin, the pin must stay low for a minimum time before it can bring the block back in. That minimum is counted in clock cycles.

Top module: `wol_power_ctrl`

## Requirements
- R1: The block enters the mode at a clock edge where `suspended` and `mode_sel` are both 1 and an armed request is present, either `sw_enable` or `hw_sleep` (both active high). `mode_active` reads 1 after that edge. Without `suspended` or without `mode_sel`, the block does not enter.
- R2: `block_master`, `block_tx` and `flush_rx` are 1 exactly while `mode_active` is 1. This keeps normal transmit and receive held off after a wake until the mode exits.
- R3: While the mode is active, a falling edge of either `sw_enable` or `hw_sleep` clears `mode_active` at the edge where the low level is first sampled.
- R4: After an exit caused by `sw_enable` falling, raising `sw_enable` again re-enters the mode at the first edge where it is sampled high.
- R5: After an exit caused by `hw_sleep` falling, entry through the pin is suppressed for HOLD_CYC = ceil(HOLD_NS*CLK_MHZ/1000) edges, which is 25 at the defaults. A pin raised early and held high enters at the 26th edge after the exit edge, and not before.
- R6: A `wake_detect` pulse sets `wake_status` when it arrives while the mode is active. A pulse that arrives while the mode is inactive leaves `wake_status` at 0.
- R7: `wake_status` is sticky. It clears only on a `wake_clr` pulse, and a detect in the same cycle wins over the clear. Leaving the mode does not clear it.
- R8: `irq` is 1 exactly when `wake_status`, `gbl_irq_en` and `wake_irq_en` are all 1.
- R9: The indicator is active when `ind_wake_sel` and `wake_status` are both 1. `ind_pin` drives the active level, which is high when `ind_pol_high` is 1 and low when it is 0, and drives the opposite level otherwise.
- R10: If the mode exits on `sw_enable` while `hw_sleep` is still high, the still-high pin does not re-enter. The pin must go low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| suspended | input | 1 | Controller suspended and traffic drained |
| mode_sel | input | 1 | Wake listening mode selected |
| sw_enable | input | 1 | Software request to enter the mode |
| hw_sleep | input | 1 | Hardware sleep request, active high |
| wake_detect | input | 1 | One-cycle pulse from the frame matcher |
| wake_clr | input | 1 | Write-one-to-clear pulse for the status bit |
| gbl_irq_en | input | 1 | Global interrupt enable |
| wake_irq_en | input | 1 | Wake interrupt enable |
| ind_wake_sel | input | 1 | Indicator pin shows wake status |
| ind_pol_high | input | 1 | Indicator active level is high |
| mode_active | output | 1 | Listening mode active |
| block_master | output | 1 | Hold off bus-master cycles |
| block_tx | output | 1 | Hold off transmit starts |
| flush_rx | output | 1 | Flush received frames |
| wake_status | output | 1 | Sticky wake status |
| irq | output | 1 | Wake interrupt |
| ind_pin | output | 1 | Wake indicator pin |

## Verification
A vector table drives all sixteen combinations of the two interrupt enables, the indicator select bit and the polarity bit while a wake is latched. This separates the AND behaviour of the interrupt from the level inversion on the indicator. Directed sequences cover entry through each path, with and without the suspend and select conditions. They cover exit on each falling edge, and show that re-entry through software is immediate while re-entry through the pin waits out the hold-off. Counting edges after a pin exit places the entry exactly one edge after the count ends, so an off-by-one in the count is caught. Further checks cover a detect arriving outside the mode, a clear that collides with a detect, and a pin left high after a software exit. Each of these separates ignoring an input from acting on it.

// File: rtl/wol_pkg.sv
package wol_pkg;
    typedef struct packed {
        logic active;
        logic sw_prev;
        logic pin_prev;
        logic sw_arm;
        logic pin_arm;
    } seq_state_t;

    localparam seq_state_t SEQ_RESET = '{active: 1'b0, sw_prev: 1'b0, pin_prev: 1'b0,
                                        sw_arm: 1'b1, pin_arm: 1'b1};

    typedef struct packed {
        logic status;
    } rpt_state_t;
endpackage

// File: rtl/wol_holdoff.sv
module wol_holdoff #(
    parameter int HOLD_CYC = 25,
    localparam int CNT_W = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    generate
        if (HOLD_CYC == 0) begin : g_none
            assign done = 1'b1;
        end else begin : g_count
            logic [CNT_W-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (start)
                    cnt_d = CNT_W'(HOLD_CYC);
                else if (cnt_q != '0)
                    cnt_d = cnt_q - 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign done = (cnt_q == '0);
        end
    endgenerate
endmodule

// File: rtl/wol_mode_seq.sv
module wol_mode_seq
    import wol_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic suspended,
    input  logic mode_sel,
    input  logic sw_enable,
    input  logic hw_sleep,
    input  logic hold_done,
    output logic active,
    output logic pin_exit
);
    seq_state_t st_d, st_q;
    logic sw_fall, pin_fall, leave, enter;

    always_comb begin
        sw_fall  = st_q.sw_prev & ~sw_enable;
        pin_fall = st_q.pin_prev & ~hw_sleep;
        leave    = st_q.active & (sw_fall | pin_fall);
        enter    = ~st_q.active & suspended & mode_sel &
                   ((sw_enable & st_q.sw_arm) | (hw_sleep & st_q.pin_arm & hold_done));

        st_d          = st_q;
        st_d.sw_prev  = sw_enable;
        st_d.pin_prev = hw_sleep;
        if (leave)      st_d.active = 1'b0;
        else if (enter) st_d.active = 1'b1;

        if (!sw_enable) st_d.sw_arm = 1'b1;
        else if (leave) st_d.sw_arm = 1'b0;

        if (!hw_sleep)  st_d.pin_arm = 1'b1;
        else if (leave) st_d.pin_arm = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEQ_RESET;
        else        st_q <= st_d;
    end

    assign active   = st_q.active;
    assign pin_exit = st_q.active & pin_fall;
endmodule

// File: rtl/wol_wake_report.sv
module wol_wake_report
    import wol_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic wake_detect,
    input  logic wake_clr,
    input  logic gbl_irq_en,
    input  logic wake_irq_en,
    input  logic ind_wake_sel,
    input  logic ind_pol_high,
    output logic status,
    output logic irq,
    output logic ind_pin
);
    rpt_state_t rs_d, rs_q;
    logic ind_on;

    always_comb begin
        rs_d = rs_q;
        if (wake_detect && active) rs_d.status = 1'b1;
        else if (wake_clr)         rs_d.status = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign status  = rs_q.status;
    assign irq     = rs_q.status & gbl_irq_en & wake_irq_en;
    assign ind_on  = rs_q.status & ind_wake_sel;
    assign ind_pin = ind_pol_high ? ind_on : ~ind_on;
endmodule

// File: rtl/wol_power_ctrl.sv
module wol_power_ctrl #(
    parameter int CLK_MHZ = 125,
    parameter int HOLD_NS = 200,
    localparam int HOLD_CYC = (HOLD_NS * CLK_MHZ + 999) / 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic suspended,
    input  logic mode_sel,
    input  logic sw_enable,
    input  logic hw_sleep,
    input  logic wake_detect,
    input  logic wake_clr,
    input  logic gbl_irq_en,
    input  logic wake_irq_en,
    input  logic ind_wake_sel,
    input  logic ind_pol_high,
    output logic mode_active,
    output logic block_master,
    output logic block_tx,
    output logic flush_rx,
    output logic wake_status,
    output logic irq,
    output logic ind_pin
);
    logic hold_done, pin_exit, active;

    wol_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk(clk), .rst_n(rst_n), .start(pin_exit), .done(hold_done)
    );

    wol_mode_seq u_seq (
        .clk(clk), .rst_n(rst_n), .suspended(suspended), .mode_sel(mode_sel),
        .sw_enable(sw_enable), .hw_sleep(hw_sleep), .hold_done(hold_done),
        .active(active), .pin_exit(pin_exit)
    );

    wol_wake_report u_rpt (
        .clk(clk), .rst_n(rst_n), .active(active), .wake_detect(wake_detect),
        .wake_clr(wake_clr), .gbl_irq_en(gbl_irq_en), .wake_irq_en(wake_irq_en),
        .ind_wake_sel(ind_wake_sel), .ind_pol_high(ind_pol_high),
        .status(wake_status), .irq(irq), .ind_pin(ind_pin)
    );

    assign mode_active  = active;
    assign block_master = active;
    assign block_tx     = active;
    assign flush_rx     = active;
endmodule

// File: rtl/wol_power_ctrl_chk.sv
module wol_power_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic suspended,
    input logic mode_sel,
    input logic sw_enable,
    input logic hw_sleep,
    input logic wake_detect,
    input logic wake_clr,
    input logic mode_active,
    input logic wake_status
);
    p_entry_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_active) |-> ($past(suspended) && $past(mode_sel)));

    p_sw_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_active && $fell(sw_enable)) |=> !mode_active);

    p_pin_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_active && $fell(hw_sleep)) |=> !mode_active);

    p_wake_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_active && wake_detect) |=> wake_status);

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_status && !wake_clr) |=> wake_status);
endmodule

bind wol_power_ctrl wol_power_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .suspended(suspended), .mode_sel(mode_sel),
    .sw_enable(sw_enable), .hw_sleep(hw_sleep), .wake_detect(wake_detect),
    .wake_clr(wake_clr), .mode_active(mode_active), .wake_status(wake_status)
);

// File: tb/wol_power_ctrl_tb_top.sv
module wol_power_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic suspended = 0, mode_sel = 0, sw_enable = 0, hw_sleep = 0;
    logic wake_detect = 0, wake_clr = 0, gbl_irq_en = 0, wake_irq_en = 0;
    logic ind_wake_sel = 0, ind_pol_high = 0;
    logic mode_active, block_master, block_tx, flush_rx, wake_status, irq, ind_pin;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    wol_power_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .suspended(suspended), .mode_sel(mode_sel),
        .sw_enable(sw_enable), .hw_sleep(hw_sleep), .wake_detect(wake_detect),
        .wake_clr(wake_clr), .gbl_irq_en(gbl_irq_en), .wake_irq_en(wake_irq_en),
        .ind_wake_sel(ind_wake_sel), .ind_pol_high(ind_pol_high),
        .mode_active(mode_active), .block_master(block_master), .block_tx(block_tx),
        .flush_rx(flush_rx), .wake_status(wake_status), .irq(irq), .ind_pin(ind_pin)
    );

    // {gbl_irq_en, wake_irq_en, ind_wake_sel, ind_pol_high, exp_irq, exp_ind}
    localparam logic [5:0] VEC [16] = '{
        6'b0000_0_1, 6'b0001_0_0, 6'b0010_0_0, 6'b0011_0_1,
        6'b0100_0_1, 6'b0101_0_0, 6'b0110_0_0, 6'b0111_0_1,
        6'b1000_0_1, 6'b1001_0_0, 6'b1010_0_0, 6'b1011_0_1,
        6'b1100_1_1, 6'b1101_1_0, 6'b1110_1_0, 6'b1111_1_1
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_gates(input string req, input logic exp);
        check(req, mode_active, exp);
        check(req, block_master, exp);
        check(req, block_tx, exp);
        check(req, flush_rx, exp);
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(3);
        // reset state
        check_gates("R2 reset", 1'b0);
        check("R7 reset", wake_status, 1'b0);
        check("R9 reset", ind_pin, 1'b1);
        rst_n = 1'b1;
        step(1);

        // R1: request without suspend/select does not enter
        sw_enable = 1; mode_sel = 1;
        step(3);
        check("R1 no suspend", mode_active, 1'b0);
        suspended = 1; mode_sel = 0;
        step(3);
        check("R1 no select", mode_active, 1'b0);

        // R6: detect outside the mode ignored
        wake_detect = 1; step(1); wake_detect = 0; step(1);
        check("R6 ignored", wake_status, 1'b0);

        mode_sel = 1;
        step(1);
        check_gates("R1 R2 enter sw", 1'b1);

        wake_detect = 1; step(1); wake_detect = 0;
        check("R6 set", wake_status, 1'b1);
        check_gates("R2 held after wake", 1'b1);

        // table: irq and indicator combinations (R8, R9)
        for (int v = 0; v < 16; v++) begin
            {gbl_irq_en, wake_irq_en, ind_wake_sel, ind_pol_high} = VEC[v][5:2];
            step(1);
            check("R8 irq", irq, VEC[v][1]);
            check("R9 ind", ind_pin, VEC[v][0]);
        end
        gbl_irq_en = 1; wake_irq_en = 1; ind_wake_sel = 1; ind_pol_high = 1;

        // R3 exit by software, R7 status survives exit
        sw_enable = 0; step(1);
        check_gates("R3 sw exit", 1'b0);
        check("R7 kept after exit", wake_status, 1'b1);
        wake_clr = 1; step(1); wake_clr = 0;
        check("R7 cleared", wake_status, 1'b0);
        check("R8 irq low", irq, 1'b0);
        check("R9 ind idle", ind_pin, 1'b0);

        // R4 immediate software re-entry
        sw_enable = 1; step(1);
        check("R4 reenter", mode_active, 1'b1);
        // R7 detect beats clear
        wake_detect = 1; wake_clr = 1; step(1); wake_detect = 0; wake_clr = 0;
        check("R7 set wins", wake_status, 1'b1);
        sw_enable = 0; step(1);
        check("R3 sw exit 2", mode_active, 1'b0);

        // pin entry and exit, R5 hold-off
        hw_sleep = 1; step(1);
        check("R1 enter pin", mode_active, 1'b1);
        hw_sleep = 0; step(1);
        check("R3 pin exit", mode_active, 1'b0);
        hw_sleep = 1;
        step(25);
        check("R5 held off", mode_active, 1'b0);
        step(1);
        check("R5 enter after hold", mode_active, 1'b1);

        // R10: software exit while pin still high
        sw_enable = 1; step(1);
        sw_enable = 0; step(1);
        check("R10 exit", mode_active, 1'b0);
        step(4);
        check("R10 pin not re-entering", mode_active, 1'b0);
        hw_sleep = 0; step(1);
        hw_sleep = 1; step(1);
        check("R10 reenter after toggle", mode_active, 1'b1);
        hw_sleep = 0; step(30);
        suspended = 0; hw_sleep = 1; step(2);
        check("R1 pin no suspend", mode_active, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule